// File: doc/BRIEF.md
# Banked GPIO Port with Masked Bit Updates

This block is a memory-mapped general-purpose I/O controller. It has a configurable number of banks, and each bank serves sixteen pins. Each bank holds four registers: an output latch, a direction word, a mode-select word and an input-enable word. A read-only level word returns what the pins currently carry. Software reaches all of them over a simple synchronous register bus. On that bus a write commits on the clock edge. Read data is a combinational function of the address.

Three of the registers also have a masked-update alias: the output latch, the direction word and the mode word. One 32-bit store to an alias carries a 16-bit select mask in its upper half and 16 new bit values in its lower half. Only the selected bits change, so firmware can flip one pin without a read-modify-write race against other code touching the same bank.

A pin is driven only when it is configured as an output and is in plain port mode. The driven level is whatever the output latch holds. Input levels pass through a two-stage synchronizer and are masked by the per-pin input enable.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is held and right after it: every direction bit reads 1 (input), and the output latch, mode and input-enable words read 0. No pin has its output enable set.
- R2: A write to offset 0x0000+4n loads bank n's output latch with wdata[15:0]. A read of that offset returns it in rdata[15:0], and rdata[31:16] is always 0.
- R3: A write to offset 0x0100+4n sets output bit i to wdata[i] if wdata[i+16] is 1 and leaves it unchanged otherwise. Reads of this alias, and of the offsets 0x0800 and 0x0900, return 0.
- R4: Offset 0x0300+4n is a plain read/write direction word (1 = input, 0 = output). Offset 0x0800+4n updates it with the same mask/value rule as R3.
- R5: Offset 0x0400+4n is a plain read/write mode word (0 = plain port). Offset 0x0900+4n updates it with the same mask/value rule.
- R6: Output enable of pin i in bank n is 1 exactly when its direction bit and its mode bit are both 0. Its pin_out level is the output latch bit. Both follow a write one clock later.
- R7: A value written to the output latch while the pin is an input is kept. It appears on the pin with output enable set once the direction bit is cleared, with no extra write.
- R8: Offset 0x4000+4n is the input-enable word. A read of the level offset 0x0200+4n returns, for each pin, the pin input seen through two flops when its enable bit is 1, and 0 when it is 0. A pin change shows in the read after the second rising edge.
- R9: Writes to the level offset have no effect on any register.
- R10: Accesses whose address is not word-aligned, whose upper byte names no register group, or whose bank index (address bits 7:2) is not below NUM_BANKS change nothing and read 0.
- R11: Each bank's registers are updated only by accesses carrying its own bank index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_we | input | 1 | Write strobe, commits on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16*NUM_BANKS | Pin input levels, bank n at bits 16n+15:16n |
| pin_out | output | 16*NUM_BANKS | Pin output levels |
| pin_oe | output | 16*NUM_BANKS | Pin output enables |

## Verification
The bench targets partial-mask alias writes with mixed ones and zeros. A design that ignored the mask or inverted its sense would corrupt bits outside the selection. It checks accesses to a bank index past the configured count and to misaligned addresses. A decoder that truncated the index would alias these onto a real bank and change its latch. It measures the two-edge input latency and the input-enable gating: a missing or extra flop moves the change to the wrong read, and a missing gate lets a disabled pin leak through. A preload while the pin is an input, then a switch to output, catches a design that clears the latch on a direction change or drives a pin that is still in alternate mode.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int PINS   = 16;
    localparam int BANK_W = 6;

    typedef enum logic [3:0] {
        GRP_NONE,
        GRP_OUT,
        GRP_OUT_ALIAS,
        GRP_LEVEL,
        GRP_DIR,
        GRP_MODE,
        GRP_DIR_ALIAS,
        GRP_MODE_ALIAS,
        GRP_IBE
    } reg_grp_e;

    typedef struct packed {
        logic [PINS-1:0] mask;
        logic [PINS-1:0] val;
    } alias_word_t;

    typedef struct packed {
        logic [PINS-1:0] out;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] mode;
        logic [PINS-1:0] ibe;
    } bank_state_t;

    function automatic reg_grp_e grp_of(input logic [7:0] hi);
        case (hi)
            8'h00:   return GRP_OUT;
            8'h01:   return GRP_OUT_ALIAS;
            8'h02:   return GRP_LEVEL;
            8'h03:   return GRP_DIR;
            8'h04:   return GRP_MODE;
            8'h08:   return GRP_DIR_ALIAS;
            8'h09:   return GRP_MODE_ALIAS;
            8'h40:   return GRP_IBE;
            default: return GRP_NONE;
        endcase
    endfunction

    function automatic logic [PINS-1:0] masked_update(input logic [PINS-1:0] old,
                                                      input alias_word_t w);
        return (old & ~w.mask) | (w.val & w.mask);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [15:0]       addr,
    output reg_grp_e          grp,
    output logic [BANK_W-1:0] bank,
    output logic              hit
);
    always_comb begin
        grp  = grp_of(addr[15:8]);
        bank = addr[7:2];
        hit  = (grp != GRP_NONE) && (addr[1:0] == 2'b00) &&
               (int'(bank) < NUM_BANKS);
    end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_grp_e    grp,
    input  logic [31:0] wdata,
    output bank_state_t state
);
    alias_word_t w;
    assign w = alias_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state.out  <= '0;
            state.dir  <= '1;
            state.mode <= '0;
            state.ibe  <= '0;
        end else if (wr_en) begin
            case (grp)
                GRP_OUT:        state.out  <= wdata[PINS-1:0];
                GRP_OUT_ALIAS:  state.out  <= masked_update(state.out, w);
                GRP_DIR:        state.dir  <= wdata[PINS-1:0];
                GRP_DIR_ALIAS:  state.dir  <= masked_update(state.dir, w);
                GRP_MODE:       state.mode <= wdata[PINS-1:0];
                GRP_MODE_ALIAS: state.mode <= masked_update(state.mode, w);
                GRP_IBE:        state.ibe  <= wdata[PINS-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [15:0]               bus_addr,
    input  logic                      bus_we,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*PINS-1:0] pin_in,
    output logic [NUM_BANKS*PINS-1:0] pin_out,
    output logic [NUM_BANKS*PINS-1:0] pin_oe
);
    localparam int TOTAL = NUM_BANKS * PINS;

    reg_grp_e          dec_grp;
    logic [BANK_W-1:0] dec_bank;
    logic              dec_hit;
    logic [TOTAL-1:0]  in_synced;
    bank_state_t       st [NUM_BANKS];

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .grp  (dec_grp),
        .bank (dec_bank),
        .hit  (dec_hit)
    );

    gpio_in_sync #(.WIDTH(TOTAL)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (in_synced)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = dec_hit && (dec_bank == BANK_W'(b));

        gpio_bank_regs u_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_we && sel),
            .grp   (dec_grp),
            .wdata (bus_wdata),
            .state (st[b])
        );

        assign pin_out[b*PINS +: PINS] = st[b].out;
        assign pin_oe[b*PINS +: PINS]  = ~st[b].dir & ~st[b].mode;
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_hit && (dec_bank == BANK_W'(b))) begin
                case (dec_grp)
                    GRP_OUT:   bus_rdata[PINS-1:0] = st[b].out;
                    GRP_LEVEL: bus_rdata[PINS-1:0] = in_synced[b*PINS +: PINS] & st[b].ibe;
                    GRP_DIR:   bus_rdata[PINS-1:0] = st[b].dir;
                    GRP_MODE:  bus_rdata[PINS-1:0] = st[b].mode;
                    GRP_IBE:   bus_rdata[PINS-1:0] = st[b].ibe;
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [15:0]             bus_addr,
    input logic                    bus_we,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [NUM_BANKS*16-1:0] pin_in,
    input logic [NUM_BANKS*16-1:0] pin_out,
    input logic [NUM_BANKS*16-1:0] pin_oe
);
    logic is_alias;
    logic unused_ok;
    assign is_alias  = (bus_addr[15:8] == 8'h01) || (bus_addr[15:8] == 8'h08) ||
                       (bus_addr[15:8] == 8'h09);
    assign unused_ok = ^{bus_wdata, pin_in};

    AST_RESET_NO_DRIVE: assert property (@(posedge clk)
        $past(rst) |-> pin_oe == '0);                                    // R1
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == 16'h0000);                                   // R2
    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        is_alias |-> bus_rdata == 32'h0);                                // R3
    AST_MISALIGNED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);                // R10
    AST_OE_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_we)) |-> $stable(pin_oe));            // R6
    AST_OUT_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_we)) |-> $stable(pin_out));           // R2
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
    localparam int NB = 4;
    localparam int NV = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NB*16-1:0]  pin_in = '0;
    logic [NB*16-1:0]  pin_out;
    logic [NB*16-1:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB)) u_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {we, addr, wdata, expected read [15:0]}
    localparam logic [64:0] VEC [NV] = '{
        {1'b1, 16'h0000, 32'h0000_A5A5, 16'h0000},  // R2 plain latch write
        {1'b0, 16'h0000, 32'h0,         16'hA5A5},  // R2
        {1'b1, 16'h0100, 32'h00FF_1234, 16'h0000},  // R3 masked low byte
        {1'b0, 16'h0000, 32'h0,         16'hA534},  // R3
        {1'b0, 16'h0100, 32'h0,         16'h0000},  // R3 alias reads 0
        {1'b1, 16'h0104, 32'hFFFF_0F0F, 16'h0000},  // R11 bank 1
        {1'b0, 16'h0004, 32'h0,         16'h0F0F},  // R11
        {1'b0, 16'h0000, 32'h0,         16'hA534},  // R11 bank 0 untouched
        {1'b1, 16'h0800, 32'h0003_0000, 16'h0000},  // R4 alias clears 2 bits
        {1'b0, 16'h0300, 32'h0,         16'hFFFC},  // R4
        {1'b1, 16'h0304, 32'h0000_1234, 16'h0000},  // R4 plain write
        {1'b0, 16'h0304, 32'h0,         16'h1234},  // R4
        {1'b1, 16'h0900, 32'h0001_0001, 16'h0000},  // R5 alias
        {1'b0, 16'h0400, 32'h0,         16'h0001},  // R5
        {1'b1, 16'h0010, 32'hFFFF_1111, 16'h0000},  // R10 bank 4 out of range
        {1'b0, 16'h0010, 32'h0,         16'h0000},  // R10
        {1'b1, 16'h0001, 32'h0000_FFFF, 16'h0000},  // R10 misaligned
        {1'b0, 16'h0000, 32'h0,         16'hA534},  // R10 latch unchanged
        {1'b0, 16'h0800, 32'h0,         16'h0000},  // R3 direction alias reads 0
        {1'b0, 16'h0900, 32'h0,         16'h0000}   // R3 mode alias reads 0
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        check(req, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd_check("R1 dir reset", 16'h0304, 32'h0000_FFFF);
        rd_check("R1 latch reset", 16'h0004, 32'h0);
        rd_check("R1 ibe reset", 16'h400C, 32'h0);
        check("R1 oe reset", 64'(pin_oe), 64'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][64]) begin
                wr(VEC[i][63:48], VEC[i][47:16]);
            end else begin
                @(negedge clk);
                rd_check($sformatf("vector %0d", i), VEC[i][63:48], {16'h0, VEC[i][15:0]});
            end
        end

        @(negedge clk);
        check("R6 oe bank0", 64'(pin_oe[15:0]), 64'h0002);
        check("R6 out bank0", 64'(pin_out[15:0]), 64'hA534);
        check("R6 oe bank1", 64'(pin_oe[31:16]), 64'hEDCB);
        check("R6 out bank1", 64'(pin_out[31:16]), 64'h0F0F);

        wr(16'h0008, 32'h0000_00C3);
        check("R7 preload not driven", 64'(pin_oe[47:32]), 64'h0);
        check("R7 preload latched", 64'(pin_out[47:32]), 64'h00C3);
        wr(16'h0808, 32'hFFFF_0000);
        check("R7 oe after switch", 64'(pin_oe[47:32]), 64'hFFFF);
        check("R7 level after switch", 64'(pin_out[47:32]), 64'h00C3);

        pin_in[63:48] = 16'h5A5A;
        repeat (3) @(negedge clk);
        rd_check("R8 disabled reads 0", 16'h020C, 32'h0);
        wr(16'h400C, 32'h0000_FFFF);
        rd_check("R8 ibe readback", 16'h400C, 32'h0000_FFFF);
        rd_check("R8 enabled level", 16'h020C, 32'h0000_5A5A);
        @(negedge clk);
        pin_in[63:48] = 16'h00FF;
        @(negedge clk);
        rd_check("R8 one edge old", 16'h020C, 32'h0000_5A5A);
        @(negedge clk);
        rd_check("R8 two edges new", 16'h020C, 32'h0000_00FF);
        wr(16'h400C, 32'h0000_000F);
        rd_check("R8 partial gate", 16'h020C, 32'h0000_000F);

        wr(16'h020C, 32'hFFFF_0000);
        rd_check("R9 level write ignored", 16'h020C, 32'h0000_000F);
        rd_check("R9 ibe intact", 16'h400C, 32'h0000_000F);
        rd_check("R9 latch intact", 16'h000C, 32'h0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rd_check("R1 dir after reset", 16'h0300, 32'h0000_FFFF);
        rd_check("R1 latch after reset", 16'h0000, 32'h0);
        rd_check("R1 mode after reset", 16'h0400, 32'h0);
        check("R1 oe after reset", 64'(pin_oe), 64'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule